// File: doc/BRIEF.md
# Per-CPU Dual-Mode Timer

This block is an array of timers, one for each processor. Each timer has two personalities, selected by one bit of a shared mode register. In counter mode the timer counts timebase ticks up to a programmed limit, raises the interrupt of its own processor and wraps to zero. In user mode the same storage forms a 54-bit free-counting value that software can start and stop, loads as two 32-bit words and never interrupts. The count sits at bit 9 of a 63-bit view, so bits 8..0 of the low word always read zero.

Software reaches the timers through word-addressed windows. Window 0 is the system window, and only its word 4 (the mode register) is implemented here. Window k+1 belongs to processor k. An external divider supplies a one-cycle `tick` pulse and advances every timer. A bus adapter outside the block drives the access strobes. The read data is combinational from the current state. Side effects of a read take place at the clock edge that ends the access.

Top module: `pct_timer_array`

## Requirements
- R1: After reset, every mode bit is 0, every irq is 0, word 3 of every processor window reads 1, and each counter runs free with limit 0. Each tick adds 1 to the count field at bit 9 of word 1.
- R2: The mode register is word 4 of window 0, and bit k selects user mode for processor k. Bits at or above NUM_CPU are not stored and read 0. A word 4 write in a processor window changes nothing.
- R3: When mode bit k goes from 0 to 1, the edge that stores it also clears irq[k], the running flag, the count and the reached flag.
- R4: When mode bit k goes from 1 to 0, the count clears, the limit becomes 0 (free-run) and the running flag becomes 1.
- R5: In user mode the 54-bit count C reads as word 0 = {reached, C[53:23]} and word 1 = {C[22:0], 9'b0}. While running, C adds 1 per tick and carries from word 1 into word 0.
- R6: In user mode, a word 0 write loads C[53:23] from wdata[30:0] and a word 1 write loads C[22:0] from wdata[31:9]. Either write clears reached and takes precedence over a tick in the same cycle.
- R7: Word 3 reads {31'b0, running} in every processor window. In user mode a word 3 write sets running to wdata[0]. In counter mode the write is ignored and the timer keeps counting.
- R8: User mode never asserts irq. A tick while C is all ones wraps C to zero and sets reached.
- R9: In counter mode, a word 0 write sets limit L = wdata[30:9] and clears the count and irq. With L nonzero, the L-th tick after that write sets reached and irq and returns the count to 0. With L = 0 the count wraps at 2^22 without any of these effects.
- R10: In counter mode, word 0 reads {1'b0, L, 9'b0} and word 1 reads {reached, count, 9'b0}. A word 0 read clears reached and irq at the edge that ends it, unless a limit match occurs at the same edge.
- R11: In counter mode, a word 2 write sets L = wdata[30:9] and leaves the count as it is.
- R12: In counter mode, a word 1 write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse that advances all timers |
| acc_wr | input | 1 | Write strobe for the addressed word |
| acc_rd | input | 1 | Read strobe (read side effects) |
| acc_win | input | WIN_W | Window: 0 system, k+1 processor k |
| acc_word | input | 3 | Word index within the window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the addressed word, combinational |
| irq | output | NUM_CPU | Per-processor interrupt, level |

## Verification
The bench builds the array with NUM_CPU = 3. With that value a window index of 2 bits still decodes all four windows, and mode bit 3 falls outside the array, so the write-ignored case for an absent processor can be seen at the read port. Three timers are enough to hold one in counter mode with an irq pending, one in counter mode mid-count and one in user mode at once. The same mode write can then show both transition directions. Random loads of the split 54-bit count, with random run lengths, test the carry from the low word into the high word. A directed load of all ones tests the wrap.

// File: rtl/pct_pkg.sv
// pct_pkg: shared constants for the per-CPU dual-mode timer.
// Assumes a 32-bit word bus and a count that sits at bit 9.
package pct_pkg;
    localparam int DATA_W = 32;
    localparam int FRAC_W = 9;                       // always-zero low bits
    localparam int LIM_W  = DATA_W - 1 - FRAC_W;     // counter-mode field (22)
    localparam int USR_W  = (DATA_W - 1) + (DATA_W - FRAC_W); // user count (54)
    localparam int HI_W   = DATA_W - 1;              // user upper field (31)
    localparam int LO_W   = DATA_W - FRAC_W;         // user lower field (23)

    typedef enum logic [2:0] {
        W_LIMIT   = 3'd0,
        W_COUNT   = 3'd1,
        W_LIM_NR  = 3'd2,
        W_RUN     = 3'd3,
        W_MODE    = 3'd4
    } word_e;
endpackage

// File: rtl/pct_mode_reg.sv
// pct_mode_reg: holds one user-mode bit per processor and reports which
// bits a write changes, so each timer can apply its transition side
// effects at the same edge the new mode is stored.
// Assumes wr is already decoded to window 0, word 4.
module pct_mode_reg #(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [NUM_CPU-1:0] wdata,
    output logic [NUM_CPU-1:0] mode_q,
    output logic [NUM_CPU-1:0] go_user,
    output logic [NUM_CPU-1:0] go_ctr
);
    // Transition pulses: bits that a write moves up or down.
    always_comb begin
        go_user = wr ? (wdata & ~mode_q) : '0;
        go_ctr  = wr ? (~wdata & mode_q) : '0;
    end

    // Mode storage.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= '0;
        else if (wr) mode_q <= wdata;
    end
endmodule

// File: rtl/pct_cell.sv
// pct_cell: one processor timer. In counter mode it counts ticks up to a
// limit and interrupts. In user mode it is a start/stop 54-bit counter
// without an interrupt. Transition pulses come from pct_mode_reg and
// take precedence over register traffic.
// Assumes wr/rd are already decoded to this timer's window.
module pct_cell
    import pct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user,
    input  logic              go_user,
    input  logic              go_ctr,
    input  logic              wr,
    input  logic              rd,
    input  logic [2:0]        word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              run
);
    logic [USR_W-1:0] cnt_q;
    logic [LIM_W-1:0] lim_q;
    logic             reached_q;
    logic             irq_q;
    logic             run_q;
    logic [LIM_W-1:0] ctr_next;
    logic             ctr_hit;
    logic             usr_wrap;

    // Next counter-mode value and limit match.
    always_comb begin
        ctr_next = cnt_q[LIM_W-1:0] + LIM_W'(1);
        ctr_hit  = (lim_q != '0) && (ctr_next == lim_q);
        usr_wrap = &cnt_q;
    end

    // State update: transitions, user mode, then counter mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else if (go_user) begin
            cnt_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b0;
        end else if (go_ctr) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else if (user) begin
            if (wr && word == W_LIMIT) begin
                cnt_q[USR_W-1:LO_W] <= wdata[HI_W-1:0];
                reached_q           <= 1'b0;
            end else if (wr && word == W_COUNT) begin
                cnt_q[LO_W-1:0] <= wdata[DATA_W-1:FRAC_W];
                reached_q       <= 1'b0;
            end else if (tick && run_q) begin
                cnt_q <= cnt_q + USR_W'(1);
                if (usr_wrap) reached_q <= 1'b1;
            end
            if (wr && word == W_RUN) run_q <= wdata[0];
        end else begin
            if (wr && word == W_LIMIT) begin
                lim_q <= wdata[DATA_W-2:FRAC_W];
                cnt_q <= '0;
                irq_q <= 1'b0;
            end else begin
                if (tick) cnt_q <= ctr_hit ? '0 : {{(USR_W-LIM_W){1'b0}}, ctr_next};
                if (tick && ctr_hit) begin
                    reached_q <= 1'b1;
                    irq_q     <= 1'b1;
                end else if (rd && word == W_LIMIT) begin
                    reached_q <= 1'b0;
                    irq_q     <= 1'b0;
                end
                if (wr && word == W_LIM_NR) lim_q <= wdata[DATA_W-2:FRAC_W];
            end
        end
    end

    // Read formatting of this timer's window.
    always_comb begin
        case (word)
            W_LIMIT: rdata = user ? {reached_q, cnt_q[USR_W-1:LO_W]}
                                  : {1'b0, lim_q, {FRAC_W{1'b0}}};
            W_COUNT: rdata = user ? {cnt_q[LO_W-1:0], {FRAC_W{1'b0}}}
                                  : {reached_q, cnt_q[LIM_W-1:0], {FRAC_W{1'b0}}};
            W_RUN:   rdata = {{(DATA_W-1){1'b0}}, run_q};
            default: rdata = '0;
        endcase
    end

    assign irq = irq_q;
    assign run = run_q;
endmodule

// File: rtl/pct_read_mux.sv
// pct_read_mux: selects the read word of the addressed window.
// Window 0 exposes only the mode register at word 4. Unknown windows read 0.
module pct_read_mux
    import pct_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int WIN_W   = 3
) (
    input  logic [WIN_W-1:0]               win,
    input  logic [2:0]                     word,
    input  logic [NUM_CPU-1:0]             mode_q,
    input  logic [NUM_CPU-1:0][DATA_W-1:0] cell_rd,
    output logic [DATA_W-1:0]              rdata
);
    // Window decode and word select.
    always_comb begin
        rdata = '0;
        if (win == '0) begin
            if (word == W_MODE) rdata = {{(DATA_W-NUM_CPU){1'b0}}, mode_q};
        end
        for (int k = 0; k < NUM_CPU; k++) begin
            if (win == WIN_W'(k + 1)) rdata = cell_rd[k];
        end
    end
endmodule

// File: rtl/pct_timer_array.sv
// pct_timer_array: top of the per-CPU dual-mode timer array. It decodes
// windows, holds the mode register and builds one pct_cell per processor.
// Assumes NUM_CPU between 1 and 16, and a one-cycle tick from outside.
module pct_timer_array
    import pct_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int WIN_W   = $clog2(NUM_CPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               acc_wr,
    input  logic               acc_rd,
    input  logic [WIN_W-1:0]   acc_win,
    input  logic [2:0]         acc_word,
    input  logic [31:0]        acc_wdata,
    output logic [31:0]        acc_rdata,
    output logic [NUM_CPU-1:0] irq
);
    logic                             mode_wr;
    logic [NUM_CPU-1:0]               mode_q;
    logic [NUM_CPU-1:0]               go_user;
    logic [NUM_CPU-1:0]               go_ctr;
    logic [NUM_CPU-1:0]               run_vec;
    logic [NUM_CPU-1:0][DATA_W-1:0]   cell_rd;

    // Mode register write decode: system window, word 4 only.
    assign mode_wr = acc_wr && (acc_win == '0) && (acc_word == W_MODE);

    pct_mode_reg #(.NUM_CPU(NUM_CPU)) mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .wdata   (acc_wdata[NUM_CPU-1:0]),
        .mode_q  (mode_q),
        .go_user (go_user),
        .go_ctr  (go_ctr)
    );

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cell
        logic sel;
        // Window match for processor k.
        assign sel = (acc_win == WIN_W'(k + 1));
        pct_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .user    (mode_q[k]),
            .go_user (go_user[k]),
            .go_ctr  (go_ctr[k]),
            .wr      (acc_wr && sel),
            .rd      (acc_rd && sel),
            .word    (acc_word),
            .wdata   (acc_wdata),
            .rdata   (cell_rd[k]),
            .irq     (irq[k]),
            .run     (run_vec[k])
        );
    end

    pct_read_mux #(.NUM_CPU(NUM_CPU), .WIN_W(WIN_W)) rmux_i (
        .win     (acc_win),
        .word    (acc_word),
        .mode_q  (mode_q),
        .cell_rd (cell_rd),
        .rdata   (acc_rdata)
    );
endmodule

// File: rtl/pct_checker.sv
// pct_checker: temporal properties of the timer array, bound to the top.
// It observes the mode register, the running flags and the interrupts.
module pct_checker #(
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [NUM_CPU-1:0] mode,
    input logic [NUM_CPU-1:0] irq,
    input logic [NUM_CPU-1:0] run
);
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
        // R8: a timer in user mode never drives its interrupt
        a_r8_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            mode[i] |-> !irq[i]);
        // R3: entering user mode leaves the timer stopped
        a_r3_enter_user_stops: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mode[i]) |-> !run[i]);
        // R4: leaving user mode starts the counter
        a_r4_leave_user_runs: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mode[i]) |-> run[i]);
        // R7: counter mode is always running
        a_r7_counter_runs: assert property (@(posedge clk) disable iff (!rst_n)
            !mode[i] |-> run[i]);
        // R9: an interrupt only rises on a tick
        a_r9_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(tick));
    end
endmodule

bind pct_timer_array pct_checker #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .mode  (mode_q),
    .irq   (irq),
    .run   (run_vec)
);

// File: tb/pct_timer_array_tb_top.sv
// Bench for pct_timer_array, built with three processors.
module pct_timer_array_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 3;
    localparam int WW         = $clog2(NCPU + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            acc_wr = 1'b0;
    logic            acc_rd = 1'b0;
    logic [WW-1:0]   acc_win = '0;
    logic [2:0]      acc_word = '0;
    logic [31:0]     acc_wdata = '0;
    logic [31:0]     acc_rdata;
    logic [NCPU-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pct_timer_array #(.NUM_CPU(NCPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_win(acc_win), .acc_word(acc_word), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int win, input int word, input logic [31:0] d);
        @(negedge clk);
        acc_win = WW'(win); acc_word = 3'(word); acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd(input int win, input int word, output logic [31:0] d);
        @(negedge clk);
        acc_win = WW'(win); acc_word = 3'(word); acc_rd = 1'b1;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int win, input int word, input logic [31:0] exp);
        logic [31:0] d;
        rd(win, word, d);
        check(req, d, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // Expected user-mode words {word0, word1} after n ticks from a load.
    function automatic logic [63:0] user_after(logic [30:0] hi, logic [31:0] lo, int unsigned n);
        logic [53:0] f;
        f = {hi, lo[31:9]} + 54'(n);
        return {1'b0, f[53:23], f[22:0], 9'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] e;
        logic [30:0] hi;
        logic [31:0] lo;
        int unsigned n;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and free-running counters
        rd_chk("R1 mode", 0, 4, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        for (int k = 1; k <= NCPU; k++) rd_chk("R1 running", k, 3, 32'h1);
        ticks(5);
        rd_chk("R1 free count", 1, 1, 32'hA00);

        // R9 limit match, R10 read side effects
        wr(2, 0, 32'h600);
        ticks(2);
        check("R9 no irq before limit", 32'(irq[1]), 32'h0);
        ticks(1);
        check("R9 irq at limit", 32'(irq[1]), 32'h1);
        rd_chk("R10 count with reached", 2, 1, 32'h8000_0000);
        rd_chk("R10 limit read", 2, 0, 32'h600);
        check("R10 read clears irq", 32'(irq[1]), 32'h0);
        rd_chk("R10 reached cleared", 2, 1, 32'h0);
        wr(2, 0, 32'h8000_0A55);
        rd_chk("R9 limit field mask", 2, 0, 32'h0A00);

        // R11 limit load without count reset
        wr(3, 0, 32'h0);
        ticks(4);
        wr(3, 2, 32'h1400);
        rd_chk("R11 count kept", 3, 1, 32'h800);
        ticks(5);
        check("R11 no irq yet", 32'(irq[2]), 32'h0);
        ticks(1);
        check("R11 irq at new limit", 32'(irq[2]), 32'h1);

        // R12 counter-mode word 1 write ignored, R7 stop ignored
        wr(1, 0, 32'h0);
        ticks(3);
        wr(1, 1, 32'hABCD_E000);
        rd_chk("R12 count unchanged", 1, 1, 32'h600);
        wr(1, 3, 32'h0);
        rd_chk("R7 counter still running", 1, 3, 32'h1);
        ticks(1);
        rd_chk("R7 counter still counts", 1, 1, 32'h800);

        // R2 mode register decode
        wr(2, 0, 32'h200);
        ticks(1);
        check("R9 irq pending before switch", 32'(irq), 32'h6);
        wr(1, 4, 32'h7);
        rd_chk("R2 per-cpu word4 ignored", 0, 4, 32'h0);
        wr(0, 4, 32'hF);
        rd_chk("R2 absent cpu bit dropped", 0, 4, 32'h7);

        // R3 entry side effects
        check("R3 irq cleared", 32'(irq), 32'h0);
        for (int k = 1; k <= NCPU; k++) begin
            rd_chk("R3 stopped", k, 3, 32'h0);
            rd_chk("R3 word0 zero", k, 0, 32'h0);
            rd_chk("R3 word1 zero", k, 1, 32'h0);
        end
        ticks(3);
        rd_chk("R3 no count while stopped", 1, 1, 32'h0);

        // R7 start/stop, R5 count step
        wr(1, 3, 32'h1);
        rd_chk("R7 started", 1, 3, 32'h1);
        ticks(3);
        rd_chk("R5 count per tick", 1, 1, 32'h600);
        wr(1, 3, 32'h0);
        ticks(2);
        rd_chk("R7 stopped holds", 1, 1, 32'h600);

        // R5/R6 split-word loads: a directed carry, then random
        for (int it = 0; it < 10; it++) begin
            if (it == 0) begin hi = 31'h12; lo = 32'hFFFF_FE00; n = 1; end
            else begin
                hi = 31'($urandom) & 31'h3FFF_FFFF;
                lo = $urandom;
                n  = 1 + ($urandom % 20);
            end
            wr(2, 0, {1'b0, hi});
            wr(2, 1, lo);
            wr(2, 3, 32'h1);
            ticks(int'(n));
            wr(2, 3, 32'h0);
            e = user_after(hi, lo, n);
            rd_chk("R5 R6 word0", 2, 0, e[63:32]);
            rd_chk("R5 R6 word1", 2, 1, e[31:0]);
            check("R8 no irq in user", 32'(irq), 32'h0);
        end

        // R8 wrap at all ones sets reached without irq
        wr(2, 0, 32'h7FFF_FFFF);
        wr(2, 1, 32'hFFFF_FFFF);
        rd_chk("R6 low bits masked", 2, 1, 32'hFFFF_FE00);
        wr(2, 3, 32'h1);
        ticks(1);
        rd_chk("R8 wrap reached", 2, 0, 32'h8000_0000);
        rd_chk("R8 wrap low zero", 2, 1, 32'h0);
        check("R8 wrap no irq", 32'(irq), 32'h0);
        wr(2, 1, 32'h0);
        rd_chk("R6 write clears reached", 2, 0, 32'h0);

        // R4 leaving user mode on processor 1 while it runs
        wr(0, 4, 32'h5);
        rd_chk("R4 mode", 0, 4, 32'h5);
        rd_chk("R4 running", 2, 3, 32'h1);
        rd_chk("R4 count cleared", 2, 1, 32'h0);
        rd_chk("R4 limit free-run", 2, 0, 32'h0);
        ticks(2);
        rd_chk("R4 counts", 2, 1, 32'h400);
        ticks(20);
        check("R4 free-run no irq", 32'(irq), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule